// File: doc/BRIEF.md
# DRAM Read Latency Sequencer

This block turns a stream of read requests, each naming a bank, a row and a column, into the command sequence a synchronous DRAM needs. It also produces the cycle on which the read data comes back. The block keeps one open-row record per bank.

A request that names the row already open in its bank is answered with a column read in the very next cycle. A request that names a different row in an open bank starts a longer sequence: the bank is closed, the target row is opened, and only then does the read go out. A request to a bank that holds no open row skips the closing step.

All delays are counted in whole clock cycles and are set by configuration inputs. These delays are the close-to-open gap, the open-to-read gap and the CAS latency. For a double-rate data path the strobe marks the clock cycle that carries both transfers of a beat, so the latency is given in clocks, not in transfers. Requests are served strictly in order. Because hits are accepted back to back, reads to open rows keep the data strobe busy on every cycle.

Top module: `dram_rd_seq`

## Requirements
- R1: During and right after synchronous reset (rst_n low), req_ready_o is 1, cmd_o is NOP (0) and rdata_valid_o is 0. Every bank starts with no open row.
- R2: A request accepted to a bank with no open row puts ACTIVATE (2) on cmd_o in the next cycle, with no PRECHARGE. READ (3) follows exactly cfg_act_gap_i cycles after the ACTIVATE.
- R3: A request accepted to an open bank whose open row differs puts PRECHARGE (1) on cmd_o in the next cycle. ACTIVATE follows exactly cfg_pre_gap_i cycles after the PRECHARGE, and READ follows exactly cfg_act_gap_i cycles after the ACTIVATE.
- R4: A request accepted to the open row of its bank puts READ on cmd_o in the next cycle. Such requests can be accepted on consecutive cycles, giving one READ per cycle.
- R5: req_ready_o is 0 from the cycle after a miss is accepted up to the cycle before its READ. It is 1 in the READ cycle and in every other cycle.
- R6: rdata_valid_o is 1 exactly cfg_cas_lat_i cycles after each cycle with READ on cmd_o (1 <= cfg_cas_lat_i <= CL_MAX), and 0 otherwise.
- R7: Command fields: cmd_bank_o carries the bank on every non-NOP command, cmd_row_o carries the row on ACTIVATE, and cmd_col_o carries the column on READ. The encoding is NOP=0, PRECHARGE=1, ACTIVATE=2, READ=3.
- R8: Banks are independent. Opening a row in one bank leaves another bank's open row in place, so a later request to that row is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cas_lat_i | input | CL_W | CAS latency in clocks, 1..CL_MAX |
| cfg_pre_gap_i | input | TIM_W | Close-to-open gap in clocks, at least 1 |
| cfg_act_gap_i | input | TIM_W | Open-to-read gap in clocks, at least 1 |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle if valid |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| cmd_o | output | 2 | Command: 0 NOP, 1 PRECHARGE, 2 ACTIVATE, 3 READ |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_row_o | output | ROW_W | Row of an ACTIVATE |
| cmd_col_o | output | COL_W | Column of a READ |
| rdata_valid_o | output | 1 | Read data present on this clock |

## Verification
The bench aims at the first touch of each bank, which must skip the close step. A design that kept stale open state would issue a spurious PRECHARGE there. It runs gaps and CAS latency at 1 and at their larger values, where an off-by-one counter shifts ACTIVATE, READ or the data strobe by a cycle. Back-to-back hits following a miss expose a ready signal that returns too late or too early, and a missing data strobe. Interleaving two banks, then returning to the first, catches a table that closes the wrong bank on an update.

// File: rtl/dram_rd_pkg.sv
// Shared command encoding for the DRAM read sequencer.
// Assumes a 2-bit command bus; the values are decoded by the command sink.
package dram_rd_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } dram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_PRE = 2'd1,
        ST_WAIT_ACT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dram_bank_table.sv
// Open-row table: one valid flag and one row register per bank.
// Looks up whether the presented bank/row is a hit and whether the bank is open.
// Assumes at most one update per cycle; all banks close at reset.
module dram_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_hit,
    output logic              lk_open,
    input  logic              upd_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);
    logic [NUM_BANKS-1:0] open_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] hit_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Record the row opened in this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (upd_en && (upd_bank == BANK_W'(b))) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= upd_row;
            end
        end
        // Per-bank comparison against the looked-up row.
        assign hit_vec[b] = open_q[b] && (row_q[b] == lk_row);
    end

    // Select the looked-up bank's result.
    always_comb begin
        lk_hit  = 1'b0;
        lk_open = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (lk_bank == BANK_W'(b)) begin
                lk_hit  = hit_vec[b];
                lk_open = open_q[b];
            end
        end
    end
endmodule

// File: rtl/dram_seq_ctrl.sv
// Command sequencer: accepts one request at a time in order, issues READ at
// once on a hit, or PRECHARGE/ACTIVATE/READ with programmed gaps on a miss.
// Assumes gap inputs are held stable while a sequence runs; a gap of 0 acts as 1.
module dram_seq_ctrl
    import dram_rd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int TIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  cfg_pre_gap,
    input  logic [TIM_W-1:0]  cfg_act_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              lk_hit,
    input  logic              lk_open,
    output logic              upd_en,
    output dram_cmd_e         cmd,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col
);
    seq_state_e       state_q;
    logic [TIM_W-1:0] wait_q;
    logic [TIM_W-1:0] pre_load;
    logic [TIM_W-1:0] act_load;
    logic             accept;

    // Ready only when no miss sequence is in flight.
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    // Open-row table is rewritten when a miss is accepted.
    assign upd_en    = accept && !lk_hit;

    // Counter preload values: gap minus one, with zero treated as one.
    assign pre_load = (cfg_pre_gap == '0) ? '0 : cfg_pre_gap - 1'b1;
    assign act_load = (cfg_act_gap == '0) ? '0 : cfg_act_gap - 1'b1;

    // State, gap counter and registered command outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wait_q   <= '0;
            cmd      <= CMD_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
        end else begin
            cmd <= CMD_NOP;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cmd_bank <= req_bank;
                        cmd_row  <= req_row;
                        cmd_col  <= req_col;
                        if (lk_hit) begin
                            cmd <= CMD_RD;
                        end else if (lk_open) begin
                            cmd     <= CMD_PRE;
                            wait_q  <= pre_load;
                            state_q <= ST_WAIT_PRE;
                        end else begin
                            cmd     <= CMD_ACT;
                            wait_q  <= act_load;
                            state_q <= ST_WAIT_ACT;
                        end
                    end
                end
                ST_WAIT_PRE: begin
                    if (wait_q == '0) begin
                        cmd     <= CMD_ACT;
                        wait_q  <= act_load;
                        state_q <= ST_WAIT_ACT;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_WAIT_ACT: begin
                    if (wait_q == '0) begin
                        cmd     <= CMD_RD;
                        state_q <= ST_IDLE;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dram_rd_pipe.sv
// Pending-read delay line: raises data-valid a programmed number of clocks
// after each READ command. Assumes 1 <= cfg_cl <= CL_MAX and a stable cfg_cl
// while reads are in flight.
module dram_rd_pipe #(
    parameter int CL_MAX = 8,
    parameter int CL_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_issue,
    input  logic [CL_W-1:0] cfg_cl,
    output logic            data_valid
);
    logic [CL_MAX:0] tap;

    assign tap[0] = rd_issue;

    for (genvar k = 1; k <= CL_MAX; k++) begin : g_stage
        // One clock of delay per stage.
        always_ff @(posedge clk) begin
            if (!rst_n) tap[k] <= 1'b0;
            else        tap[k] <= tap[k-1];
        end
    end

    // Pick the stage matching the programmed latency.
    always_comb begin
        data_valid = 1'b0;
        for (int k = 1; k <= CL_MAX; k++) begin
            if (cfg_cl == CL_W'(k)) data_valid = tap[k];
        end
    end
endmodule

// File: rtl/dram_rd_seq.sv
// Top of the DRAM read sequencer: open-row table, command sequencer and
// read-data delay line. Assumes configuration changes only while idle and
// with no reads in flight.
module dram_rd_seq
    import dram_rd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int CL_MAX    = 8,
    parameter int TIM_W     = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int CL_W     = $clog2(CL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CL_W-1:0]   cfg_cas_lat_i,
    input  logic [TIM_W-1:0]  cfg_pre_gap_i,
    input  logic [TIM_W-1:0]  cfg_act_gap_i,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    output logic [1:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    output logic [COL_W-1:0]  cmd_col_o,
    output logic              rdata_valid_o
);
    logic      lk_hit;
    logic      lk_open;
    logic      upd_en;
    dram_cmd_e cmd;

    dram_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bank  (req_bank_i),
        .lk_row   (req_row_i),
        .lk_hit   (lk_hit),
        .lk_open  (lk_open),
        .upd_en   (upd_en),
        .upd_bank (req_bank_i),
        .upd_row  (req_row_i)
    );

    dram_seq_ctrl #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .TIM_W  (TIM_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_pre_gap (cfg_pre_gap_i),
        .cfg_act_gap (cfg_act_gap_i),
        .req_valid   (req_valid_i),
        .req_ready   (req_ready_o),
        .req_bank    (req_bank_i),
        .req_row     (req_row_i),
        .req_col     (req_col_i),
        .lk_hit      (lk_hit),
        .lk_open     (lk_open),
        .upd_en      (upd_en),
        .cmd         (cmd),
        .cmd_bank    (cmd_bank_o),
        .cmd_row     (cmd_row_o),
        .cmd_col     (cmd_col_o)
    );

    dram_rd_pipe #(
        .CL_MAX (CL_MAX),
        .CL_W   (CL_W)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue   (cmd == CMD_RD),
        .cfg_cl     (cfg_cas_lat_i),
        .data_valid (rdata_valid_o)
    );

    assign cmd_o = cmd;
endmodule

// File: rtl/dram_rd_seq_chk.sv
// Protocol checker for the DRAM read sequencer, observing ports only.
// Assumes configuration is stable while commands are in flight.
module dram_rd_seq_chk
    import dram_rd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int CL_MAX = 8,
    parameter int CL_W   = 4,
    parameter int TIM_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CL_W-1:0]   cfg_cas_lat_i,
    input logic [TIM_W-1:0]  cfg_pre_gap_i,
    input logic [TIM_W-1:0]  cfg_act_gap_i,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic [1:0]        cmd_o,
    input logic              rdata_valid_o
);
    logic [TIM_W:0]  gap_pre;
    logic [TIM_W:0]  gap_act;
    logic            after_pre;
    logic            after_act;
    logic [CL_MAX:1] rd_hist;
    logic            want_valid;

    // Cycles since the last PRECHARGE and since the last ACTIVATE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_pre   <= '0;
            gap_act   <= '0;
            after_pre <= 1'b0;
            after_act <= 1'b0;
        end else begin
            if (cmd_o == CMD_PRE)    gap_pre <= 1;
            else if (~&gap_pre)      gap_pre <= gap_pre + 1'b1;
            if (cmd_o == CMD_ACT)    gap_act <= 1;
            else if (~&gap_act)      gap_act <= gap_act + 1'b1;
            if (cmd_o == CMD_PRE)      after_pre <= 1'b1;
            else if (cmd_o == CMD_ACT) after_pre <= 1'b0;
            if (cmd_o == CMD_ACT)      after_act <= 1'b1;
            else if (cmd_o == CMD_RD)  after_act <= 1'b0;
        end
    end

    // History of READ commands seen on the port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_hist <= '0;
        else        rd_hist <= {rd_hist[CL_MAX-1:1], cmd_o == CMD_RD};
    end

    always_comb begin
        want_valid = 1'b0;
        for (int k = 1; k <= CL_MAX; k++) begin
            if (cfg_cas_lat_i == CL_W'(k)) want_valid = rd_hist[k];
        end
    end

    assert_accept_next_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> (cmd_o != CMD_NOP));

    assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE || cmd_o == CMD_ACT) |-> !req_ready_o);

    assert_pre_to_act_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && after_pre) |-> (gap_pre == {1'b0, cfg_pre_gap_i}));

    assert_act_to_rd_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_RD && after_act) |-> (gap_act == {1'b0, cfg_act_gap_i}));

    assert_valid_after_cl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid_o == want_valid);
endmodule

bind dram_rd_seq dram_rd_seq_chk #(
    .BANK_W (BANK_W),
    .CL_MAX (CL_MAX),
    .CL_W   (CL_W),
    .TIM_W  (TIM_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_cas_lat_i (cfg_cas_lat_i),
    .cfg_pre_gap_i (cfg_pre_gap_i),
    .cfg_act_gap_i (cfg_act_gap_i),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .cmd_o         (cmd_o),
    .rdata_valid_o (rdata_valid_o)
);

// File: tb/tb_dram_rd_seq.sv
// Bench for the DRAM read sequencer: a behavioural schedule of expected
// commands, ready and data-valid per cycle, compared at every falling edge.
module tb_dram_rd_seq;
    localparam int NB  = 4;
    localparam int RW  = 13;
    localparam int CW  = 10;
    localparam int CLM = 8;
    localparam int TW  = 4;
    localparam int BW  = 2;
    localparam int CLW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CLW-1:0] cfg_cl = 4'd3;
    logic [TW-1:0] cfg_pre = 4'd2;
    logic [TW-1:0] cfg_act = 4'd3;
    logic          req_valid = 1'b0;
    logic          req_ready_o;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [1:0]    cmd_o;
    logic [BW-1:0] cmd_bank_o;
    logic [RW-1:0] cmd_row_o;
    logic [CW-1:0] cmd_col_o;
    logic          rdata_valid_o;

    always #4 clk = ~clk;

    dram_rd_seq #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .CL_MAX(CLM), .TIM_W(TW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_cas_lat_i(cfg_cl), .cfg_pre_gap_i(cfg_pre), .cfg_act_gap_i(cfg_act),
        .req_valid_i(req_valid), .req_ready_o(req_ready_o),
        .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
        .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_row_o(cmd_row_o),
        .cmd_col_o(cmd_col_o), .rdata_valid_o(rdata_valid_o)
    );

    int    cyc = 0;
    int    errors = 0;
    int    checks = 0;
    bit    run_checks = 1'b0;
    bit    done = 1'b0;
    int    busy_until = 0;
    int    exp_cmd [int];
    int    exp_b [int];
    int    exp_r [int];
    int    exp_c [int];
    string exp_tag [int];
    bit    exp_v [int];
    bit    mdl_open [NB];
    int    mdl_row [NB];
    string req_tag = "";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic sched(int at, int c, int b, int r, int col, string tag);
        exp_cmd[at] = c;
        exp_b[at]   = b;
        exp_r[at]   = r;
        exp_c[at]   = col;
        exp_tag[at] = tag;
    endtask

    // Compare outputs with the schedule, then model an acceptance at the next edge.
    always @(negedge clk) begin
        if (run_checks) begin
            int    ec;
            string t;
            int    n;
            int    b;
            int    rdc;
            ec = exp_cmd.exists(cyc) ? exp_cmd[cyc] : 0;
            t  = exp_tag.exists(cyc) ? exp_tag[cyc] : "R4";
            chk(int'(cmd_o) == ec, t, "command", int'(cmd_o), ec);
            if (ec != 0) begin
                chk(int'(cmd_bank_o) == exp_b[cyc], "R7", "bank", int'(cmd_bank_o), exp_b[cyc]);
                if (ec == 2) chk(int'(cmd_row_o) == exp_r[cyc], "R7", "row", int'(cmd_row_o), exp_r[cyc]);
                if (ec == 3) chk(int'(cmd_col_o) == exp_c[cyc], "R7", "column", int'(cmd_col_o), exp_c[cyc]);
            end
            chk(req_ready_o == (cyc >= busy_until), "R5", "ready",
                int'(req_ready_o), int'(cyc >= busy_until));
            chk(rdata_valid_o == exp_v.exists(cyc), "R6", "data valid",
                int'(rdata_valid_o), int'(exp_v.exists(cyc)));
            if (req_valid && cyc >= busy_until) begin
                n = cyc + 1;
                b = int'(req_bank);
                if (mdl_open[b] && mdl_row[b] == int'(req_row)) begin
                    rdc = n;
                end else if (mdl_open[b]) begin
                    sched(n, 1, b, 0, 0, req_tag);
                    sched(n + int'(cfg_pre), 2, b, int'(req_row), 0, req_tag);
                    rdc = n + int'(cfg_pre) + int'(cfg_act);
                end else begin
                    sched(n, 2, b, int'(req_row), 0, req_tag);
                    rdc = n + int'(cfg_act);
                end
                sched(rdc, 3, b, 0, int'(req_col), req_tag);
                busy_until = rdc;
                exp_v[rdc + int'(cfg_cl)] = 1'b1;
                mdl_open[b] = 1'b1;
                mdl_row[b]  = int'(req_row);
            end
        end
    end

    // Present one request from posedge+2 and hold it until accepted.
    task automatic send(int b, int r, int c, string tag);
        bit acc;
        acc       = 1'b0;
        req_valid = 1'b1;
        req_bank  = BW'(b);
        req_row   = RW'(r);
        req_col   = CW'(c);
        req_tag   = tag;
        while (!acc) begin
            @(negedge clk);
            acc = req_ready_o;
            @(posedge clk);
            #2;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 50000, 0);
        summary();
        $finish;
    end

    initial begin
        foreach (mdl_open[i]) begin
            mdl_open[i] = 1'b0;
            mdl_row[i]  = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready_o == 1'b1, "R1", "ready in reset", int'(req_ready_o), 1);
        chk(cmd_o == 2'd0, "R1", "command in reset", int'(cmd_o), 0);
        chk(rdata_valid_o == 1'b0, "R1", "data valid in reset", int'(rdata_valid_o), 0);
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        busy_until = cyc;
        run_checks = 1'b1;

        // Phase A: pre gap 2, act gap 3, CAS latency 3
        send(0, 5, 1, "R2");     // closed bank: no precharge
        send(0, 5, 2, "R4");     // hit
        send(0, 5, 3, "R4");     // back-to-back hit
        send(1, 7, 4, "R2");     // other bank, first touch
        send(0, 5, 5, "R8");     // bank 0 row still open
        send(0, 9, 6, "R3");     // row miss in open bank
        send(0, 9, 7, "R4");
        send(0, 9, 8, "R4");
        idle(20);

        // Phase B: all delays at their minimum of 1
        cfg_pre = 4'd1; cfg_act = 4'd1; cfg_cl = 4'd1;
        idle(2);
        send(1, 8, 1, "R3");
        send(2, 1, 2, "R2");
        send(2, 1, 3, "R4");
        send(1, 8, 9, "R8");
        send(1, 8, 10, "R6");
        idle(20);

        // Phase C: longest CAS latency, uneven gaps
        cfg_pre = 4'd3; cfg_act = 4'd2; cfg_cl = 4'(CLM);
        idle(2);
        send(3, 4, 0, "R2");
        send(3, 4, 1023, "R7");
        send(3, 5, 0, "R3");
        send(3, 4, 0, "R3");
        send(3, 4, 2, "R6");
        send(3, 4, 3, "R6");
        idle(20);

        summary();
        $finish;
    end
endmodule